// File: doc/BRIEF.md
# Free-Running Tick Timer with Coherent Split Read

This block is a 12-bit up-counter that advances once for every cycle in which a 1 µs tick enable is high, wrapping to zero after 4096 ticks. Software reads it over an 8-bit read port. The count spans roughly 4 ms, so any event shorter than that can be timed by taking the difference of two readings.

Because the count is wider than the data bus, a read is done in two steps. The low-byte read also captures the top four count bits into a shadow register. The later high read returns that shadow and not the live count. The two halves therefore always belong to the same instant, however long software waits between them. The block also raises two periodic interrupt pulses taken from count bits 6 and 9. These pulses come every 128 ticks and every 1024 ticks.

Top module: `freerun_timer`

## Requirements
- R1: After reset the count and the shadow are zero, `rd_data` is 0x00 and both interrupt outputs are low. The first high read after reset returns 0x00.
- R2: The count grows by exactly one in each cycle where `tick_en` is high and holds otherwise. After 4095 it wraps to 0.
- R3: A read with `rd_en` high and `rd_addr` = 0x24 places count bits 7..0, as they were in the read cycle, on `rd_data` from the next cycle. A tick in the same cycle does not change the value returned.
- R4: The same low read loads count bits 11..8 of the read cycle into the shadow. When a tick falls in that cycle, the shadow takes the pre-increment bits that match the returned low byte.
- R5: A read at 0x25 returns the shadow in `rd_data` bits 3..0 and zeros in bits 7..4. It leaves the shadow unchanged.
- R6: Reads at any address never alter the count.
- R7: `irq_fast` is high for exactly one cycle, in the cycle after the count steps to a multiple of 128 (count bit 6 falls). It is low at all other times.
- R8: `irq_slow` is high for exactly one cycle, in the cycle after the count steps to a multiple of 1024 (count bit 9 falls). It is low at all other times.
- R9: A read at any address other than 0x24 or 0x25 returns 0x00 and leaves the shadow unchanged. Between reads, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 1 µs count enable |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| irq_fast | output | 1 | Pulse every 128 ticks |
| irq_slow | output | 1 | Pulse every 1024 ticks |

## Verification
Two things can land in one cycle: the shadow capture caused by a low read, and a count increment caused by a tick. The bench forces this on purpose at count 0x1FF, where the increment also changes the upper bits. It also gets there many times by chance under random stimulus. The result is judged on the following high read, which must return the upper bits of the pre-increment value that matches the low byte already returned. Interrupt pulses are compared against a bench model in every cycle, including the wraps where both taps fall together.

// File: rtl/ftimer_pkg.sv
package ftimer_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_BAD  = 2'd3
  } rd_sel_e;

  // A tap bit that was high and is now low marks a period boundary.
  function automatic logic tap_fell(input logic was, input logic now);
    return was & ~now;
  endfunction

endpackage

// File: rtl/ft_counter.sv
module ft_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tick_en) cnt <= bump(cnt);
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

endmodule

// File: rtl/ft_decode.sv
module ft_decode #(
  parameter int unsigned        ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h25
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output ftimer_pkg::rd_sel_e sel
);
  import ftimer_pkg::*;

  always_comb begin
    if (!rd_en)                sel = SEL_NONE;
    else if (rd_addr == LO_ADDR) sel = SEL_LO;
    else if (rd_addr == HI_ADDR) sel = SEL_HI;
    else                       sel = SEL_BAD;
  end

endmodule

// File: rtl/ft_shadow.sv
module ft_shadow #(
  parameter int unsigned HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] shadow
);

  always_ff @(posedge clk) begin
    if (!rst_n)       shadow <= '0;
    else if (capture) shadow <= hi_in;
  end

  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> shadow == $past(hi_in));

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(shadow));

endmodule

// File: rtl/ft_edge_irq.sv
module ft_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_bit,
  output logic irq
);
  import ftimer_pkg::*;

  logic tap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tap_q <= 1'b0;
    else        tap_q <= tap_bit;
  end

  assign irq = tap_fell(tap_q, tap_bit);

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_tap_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !tap_bit && $past(tap_bit));

endmodule

// File: rtl/freerun_timer.sv
module freerun_timer #(
  parameter int unsigned        CNT_W    = 12,
  parameter int unsigned        DATA_W   = 8,
  parameter int unsigned        ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h24,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h25,
  parameter int unsigned        FAST_TAP = 6,
  parameter int unsigned        SLOW_TAP = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_fast,
  output logic              irq_slow
);
  import ftimer_pkg::*;

  localparam int unsigned HI_W   = CNT_W - DATA_W;
  localparam int unsigned N_TAPS = 2;

  logic [CNT_W-1:0]  cnt;
  logic [HI_W-1:0]   shadow;
  logic [N_TAPS-1:0] irq_vec;
  rd_sel_e           sel;
  logic              lo_read;
  logic              hi_read;

  ft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt)
  );

  ft_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
    .rd_en(rd_en), .rd_addr(rd_addr), .sel(sel)
  );

  assign lo_read = (sel == SEL_LO);
  assign hi_read = (sel == SEL_HI);

  ft_shadow #(.HI_W(HI_W)) u_shd (
    .clk(clk), .rst_n(rst_n), .capture(lo_read),
    .hi_in(cnt[CNT_W-1:DATA_W]), .shadow(shadow)
  );

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int unsigned TAP = (g == 0) ? FAST_TAP : SLOW_TAP;
    ft_edge_irq u_irq (
      .clk(clk), .rst_n(rst_n), .tap_bit(cnt[TAP]), .irq(irq_vec[g])
    );
  end

  assign irq_fast = irq_vec[0];
  assign irq_slow = irq_vec[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      unique case (sel)
        SEL_LO:   rd_data <= cnt[DATA_W-1:0];
        SEL_HI:   rd_data <= {{(DATA_W-HI_W){1'b0}}, shadow};
        SEL_BAD:  rd_data <= '0;
        default:  rd_data <= rd_data;
      endcase
    end
  end

  p_hi_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_read |=> rd_data[DATA_W-1:HI_W] == '0);

  p_lo_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_read |=> rd_data == $past(cnt[DATA_W-1:0]));

  p_bad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_BAD) |=> rd_data == '0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> rd_data == '0 && !irq_fast && !irq_slow);

endmodule

// File: tb/freerun_timer_tb.sv
`timescale 1ns/1ps
module freerun_timer_tb;

  localparam logic [7:0] A_LO = 8'h24;
  localparam logic [7:0] A_HI = 8'h25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       irq_fast, irq_slow;

  int n_chk = 0;
  int n_bad = 0;

  logic [11:0] m_cnt = '0;
  logic [3:0]  m_shd = '0;

  always #4 clk = ~clk;

  freerun_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_fast(irq_fast), .irq_slow(irq_slow)
  );

  function automatic logic crossed(input logic [11:0] a, input logic [11:0] b, input int unsigned per);
    return (a != b) && ((b % per) == 0);
  endfunction

  function automatic logic [7:0] read_model(input logic [7:0] a, input logic [11:0] c, input logic [3:0] s);
    if (a == A_LO)      return c[7:0];
    else if (a == A_HI) return {4'h0, s};
    else                return 8'h00;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic r, input logic [7:0] a);
    logic [11:0] prev;
    logic [7:0]  exp_rd;
    @(negedge clk);
    tick_en = t; rd_en = r; rd_addr = a;
    @(posedge clk);
    #1;
    prev = m_cnt;
    exp_rd = read_model(a, prev, m_shd);
    if (r && a == A_LO) m_shd = prev[11:8];
    if (t) m_cnt = prev + 12'd1;
    chk("R7 irq_fast", int'(irq_fast), int'(crossed(prev, m_cnt, 128)));
    chk("R8 irq_slow", int'(irq_slow), int'(crossed(prev, m_cnt, 1024)));
    if (r) begin
      if (a == A_LO)      chk("R3 low read", int'(rd_data), int'(exp_rd));
      else if (a == A_HI) chk("R5 high read", int'(rd_data), int'(exp_rd));
      else                chk("R9 unmapped read", int'(rd_data), int'(exp_rd));
    end
  endtask

  task automatic idle;
    @(negedge clk);
    tick_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_data reset", int'(rd_data), 0);
    chk("R1 irq_fast reset", int'(irq_fast), 0);
    chk("R1 irq_slow reset", int'(irq_slow), 0);
    @(negedge clk); rst_n = 1'b1;

    step(1'b0, 1'b1, A_HI);
    chk("R1 shadow after reset", int'(rd_data), 0);

    repeat (300) step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, A_LO);
    chk("R2 low after 300 ticks", int'(rd_data), 300 % 256);
    step(1'b0, 1'b1, A_HI);
    chk("R2 high after 300 ticks", int'(rd_data), 1);

    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, (i % 3 == 0) ? A_HI : A_LO);
    idle();
    repeat (20) @(posedge clk);
    step(1'b0, 1'b1, 8'h7e);
    chk("R9 holds shadow", int'(rd_data), 0);
    step(1'b0, 1'b1, A_HI);
    chk("R9 shadow untouched", int'(rd_data), 1);
    step(1'b0, 1'b1, A_LO);
    chk("R6 count unchanged by reads", int'(rd_data), 300 % 256);

    while (m_cnt != 12'h1FF) step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, A_LO);
    chk("R3 low with coincident tick", int'(rd_data), 8'hFF);
    step(1'b0, 1'b1, A_HI);
    chk("R4 pre-increment high", int'(rd_data), 1);
    step(1'b0, 1'b1, A_LO);
    chk("R4 live count moved on", int'(rd_data), 0);

    while (m_cnt != 12'hFFF) step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, A_LO);
    chk("R2 low at top", int'(rd_data), 8'hFF);
    step(1'b0, 1'b1, A_HI);
    chk("R2 high at top", int'(rd_data), 8'h0F);
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, A_LO);
    chk("R2 wrap low", int'(rd_data), 0);
    step(1'b0, 1'b1, A_HI);
    chk("R2 wrap high", int'(rd_data), 0);

    for (int i = 0; i < 20000; i++) begin
      logic [7:0] a;
      int unsigned pick;
      pick = $urandom % 6;
      case (pick)
        0, 1:    a = A_LO;
        2:       a = A_HI;
        3:       a = 8'h23;
        4:       a = 8'h26;
        default: a = 8'($urandom);
      endcase
      step(($urandom % 4) != 0, ($urandom % 5) < 2, a);
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule